// File: doc/BRIEF.md
# Word-Granular Stash Coherence Controller

This block tracks coherence for a software-managed stash. Each stash line has one address tag, and every word in the line has its own coherence state. Each word is in one of three stable states. There are no transient states, and the block keeps no list of sharers. A compute unit issues loads and stores on a single-beat local access port. The controller answers each access with a hit flag in the same cycle.

On a miss, the controller sends one request toward the shared last-level cache:
- A load miss sends a plain read.
- A store miss sends a registration. A registration carries the core's identity and the stash-map index of the word, so the cache can record where the current copy lives.

Responses and acknowledgements come back with a per-word mask. Only the masked words change.

A one-cycle kernel-end pulse runs a bulk self-invalidation:
- Registered words stay as they are.
- Every other word drops to Invalid.

If a registration is still in flight, the pulse is parked until that registration completes. Each line allows at most one outstanding miss. A per-line busy flag holds back any further access to that line.

Top module: `stash_coh_ctrl`

## Requirements
- R1: After reset every line's tag is unset and every word is Invalid (encoding Invalid=0, Valid=1, Registered=2), so every first access misses, `acc_ready` is 1 and `req_valid` is 0.
- R2: A store (`acc_write`=1) hits only on a Registered word. A store miss raises `req_valid` on the cycle after acceptance with `req_register`=1.
- R3: A registration request carries `req_core` equal to the `CORE_ID` parameter, `req_map_idx` equal to the accepted `acc_map_idx`, and the accessed line, word and tag.
- R4: A load hits on a Valid or Registered word. A load to an Invalid word issues a request with `req_register`=0, and a read response makes that word Valid.
- R5: A response updates only the words whose bit is set in `rsp_mask` (bit n is word n). A read response never downgrades a Registered word.
- R6: A response with `rsp_register`=1 moves the masked words to Registered. Any response to a line clears that line's busy flag.
- R7: `acc_ready` is 0 in three cases: while `req_valid` is 1, while the addressed line has a miss outstanding, and while a kernel end is waiting.
- R8: While `req_valid`=1 and `req_ready`=0, the request and its fields hold stable.
- R9: After a `kernel_end` pulse with no registration outstanding, Registered words stay Registered and all other words become Invalid.
- R10: A `kernel_end` pulse that arrives while a registration is outstanding is held. It is applied on the clock edge after the acknowledging response.
- R11: An access whose tag differs from the line's tag misses. When that miss issues, the line takes the new tag and all of its words become Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Local access present |
| acc_ready | output | 1 | Access can be accepted this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_line | input | LINE_W | Stash line index |
| acc_word | input | WORD_W | Word within the line |
| acc_tag | input | TAG_W | Address tag of the access |
| acc_map_idx | input | MAP_W | Stash-map index of the word |
| acc_hit | output | 1 | Combinational hit result for the presented access |
| req_valid | output | 1 | Request to the shared cache pending |
| req_ready | input | 1 | Shared cache takes the request |
| req_register | output | 1 | 1 = registration, 0 = read |
| req_core | output | CORE_W | Requesting core identity |
| req_map_idx | output | MAP_W | Stash-map index for the registration |
| req_line | output | LINE_W | Line of the miss |
| req_word | output | WORD_W | Word of the miss |
| req_tag | output | TAG_W | Tag of the miss |
| rsp_valid | input | 1 | Response or acknowledgement present |
| rsp_register | input | 1 | 1 = registration ack, 0 = read data |
| rsp_line | input | LINE_W | Line the response applies to |
| rsp_mask | input | WORDS | Words carried by the response |
| kernel_end | input | 1 | One-cycle kernel-end pulse |

## Verification
There is no added latency on the hit flag: it is combinational, so the bench samples it one nanosecond after driving an access and before the accepting edge. A miss shows up as `req_valid` and its fields one edge after acceptance. The bench therefore reads them just after that edge.

State changes from a response or an unheld kernel end take effect at the edge that samples them. The bench observes those changes only through later accesses. A held kernel end lands one edge after the acknowledgement, so the bench waits one more cycle before probing.

// File: rtl/stash_coh_pkg.sv
package stash_coh_pkg;
   typedef enum logic [1:0] {
      WS_INV = 2'd0,
      WS_VAL = 2'd1,
      WS_REG = 2'd2
   } word_st_e;
endpackage

// File: rtl/stash_line_state.sv
module stash_line_state
   import stash_coh_pkg::*;
#(
   parameter int WORDS = 16,
   parameter int TAG_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alloc,
   input  logic [TAG_W-1:0]   alloc_tag,
   input  logic               rsp_en,
   input  logic               rsp_reg,
   input  logic [WORDS-1:0]   rsp_mask,
   input  logic               kend_fire,
   output logic [TAG_W-1:0]   tag_q,
   output logic               tag_ok_q,
   output logic [2*WORDS-1:0] st_vec
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q    <= '0;
         tag_ok_q <= 1'b0;
      end else if (alloc) begin
         tag_q    <= alloc_tag;
         tag_ok_q <= 1'b1;
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      word_st_e st_q, st_d;
      always_comb begin
         st_d = st_q;
         if (alloc) begin
            st_d = WS_INV;
         end else begin
            if (kend_fire && st_q != WS_REG) st_d = WS_INV;
            if (rsp_en && rsp_mask[w]) begin
               if (rsp_reg)            st_d = WS_REG;
               else if (st_d != WS_REG) st_d = WS_VAL;
            end
         end
      end
      always_ff @(posedge clk) begin
         if (!rst_n) st_q <= WS_INV;
         else        st_q <= st_d;
      end
      assign st_vec[2*w +: 2] = st_q;
   end
endmodule

// File: rtl/stash_miss_tracker.sv
module stash_miss_tracker #(
   parameter int NUM_LINES = 4,
   parameter int WORDS     = 16,
   parameter int TAG_W     = 20,
   parameter int MAP_W     = 6,
   localparam int LINE_W   = $clog2(NUM_LINES),
   localparam int WORD_W   = $clog2(WORDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue,
   input  logic                 issue_reg,
   input  logic [LINE_W-1:0]    issue_line,
   input  logic [WORD_W-1:0]    issue_word,
   input  logic [TAG_W-1:0]     issue_tag,
   input  logic [MAP_W-1:0]     issue_map,
   input  logic                 req_ready,
   input  logic                 rsp_valid,
   input  logic [LINE_W-1:0]    rsp_line,
   output logic                 req_valid,
   output logic                 req_register,
   output logic [LINE_W-1:0]    req_line,
   output logic [WORD_W-1:0]    req_word,
   output logic [TAG_W-1:0]     req_tag,
   output logic [MAP_W-1:0]     req_map_idx,
   output logic [NUM_LINES-1:0] busy,
   output logic                 reg_busy_any
);
   logic [NUM_LINES-1:0] reg_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_valid    <= 1'b0;
         req_register <= 1'b0;
         req_line     <= '0;
         req_word     <= '0;
         req_tag      <= '0;
         req_map_idx  <= '0;
      end else if (issue) begin
         req_valid    <= 1'b1;
         req_register <= issue_reg;
         req_line     <= issue_line;
         req_word     <= issue_word;
         req_tag      <= issue_tag;
         req_map_idx  <= issue_map;
      end else if (req_ready) begin
         req_valid    <= 1'b0;
      end
   end

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic hit_issue, hit_rsp;
      assign hit_issue = issue && (issue_line == LINE_W'(l));
      assign hit_rsp   = rsp_valid && (rsp_line == LINE_W'(l));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy[l]     <= 1'b0;
            reg_busy[l] <= 1'b0;
         end else if (hit_issue) begin
            busy[l]     <= 1'b1;
            reg_busy[l] <= issue_reg;
         end else if (hit_rsp) begin
            busy[l]     <= 1'b0;
            reg_busy[l] <= 1'b0;
         end
      end
   end

   assign reg_busy_any = |reg_busy;
endmodule

// File: rtl/stash_kend_seq.sv
module stash_kend_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic kend_pulse,
   input  logic reg_busy_any,
   output logic fire,
   output logic hold_q
);
   logic want;
   assign want = kend_pulse || hold_q;
   assign fire = want && !reg_busy_any;

   always_ff @(posedge clk) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= want && reg_busy_any;
   end
endmodule

// File: rtl/stash_coh_ctrl.sv
module stash_coh_ctrl
   import stash_coh_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int WORDS     = 16,
   parameter int TAG_W     = 20,
   parameter int CORE_W    = 4,
   parameter int CORE_ID   = 3,
   parameter int MAP_W     = 6,
   localparam int LINE_W   = $clog2(NUM_LINES),
   localparam int WORD_W   = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   output logic              acc_ready,
   input  logic              acc_write,
   input  logic [LINE_W-1:0] acc_line,
   input  logic [WORD_W-1:0] acc_word,
   input  logic [TAG_W-1:0]  acc_tag,
   input  logic [MAP_W-1:0]  acc_map_idx,
   output logic              acc_hit,
   output logic              req_valid,
   input  logic              req_ready,
   output logic              req_register,
   output logic [CORE_W-1:0] req_core,
   output logic [MAP_W-1:0]  req_map_idx,
   output logic [LINE_W-1:0] req_line,
   output logic [WORD_W-1:0] req_word,
   output logic [TAG_W-1:0]  req_tag,
   input  logic              rsp_valid,
   input  logic              rsp_register,
   input  logic [LINE_W-1:0] rsp_line,
   input  logic [WORDS-1:0]  rsp_mask,
   input  logic              kernel_end
);
   if (NUM_LINES < 2 || (1 << LINE_W) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two, at least 2");
   end
   if (WORDS < 2 || (1 << WORD_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two, at least 2");
   end
   if (CORE_ID >= (1 << CORE_W)) begin : g_bad_core
      $error("CORE_ID does not fit in CORE_W bits");
   end

   logic [TAG_W-1:0]   line_tag [NUM_LINES];
   logic [NUM_LINES-1:0] line_tag_ok;
   logic [2*WORDS-1:0] line_st [NUM_LINES];
   logic [NUM_LINES-1:0] busy;
   logic               reg_busy_any, kend_fire, kend_hold;
   logic               tag_match, accept, issue;
   word_st_e           look_st;

   assign tag_match = line_tag_ok[acc_line] && (line_tag[acc_line] == acc_tag);
   assign look_st   = tag_match ? word_st_e'(line_st[acc_line][2*acc_word +: 2]) : WS_INV;
   assign acc_hit   = acc_write ? (look_st == WS_REG) : (look_st != WS_INV);
   assign acc_ready = !req_valid && !busy[acc_line] && !kend_hold;
   assign accept    = acc_valid && acc_ready;
   assign issue     = accept && !acc_hit;
   assign req_core  = CORE_W'(CORE_ID);

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic alloc_l, rsp_l;
      assign alloc_l = issue && !tag_match && (acc_line == LINE_W'(l));
      assign rsp_l   = rsp_valid && (rsp_line == LINE_W'(l));
      stash_line_state #(.WORDS(WORDS), .TAG_W(TAG_W)) i_line (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc     (alloc_l),
         .alloc_tag (acc_tag),
         .rsp_en    (rsp_l),
         .rsp_reg   (rsp_register),
         .rsp_mask  (rsp_mask),
         .kend_fire (kend_fire),
         .tag_q     (line_tag[l]),
         .tag_ok_q  (line_tag_ok[l]),
         .st_vec    (line_st[l])
      );
   end

   stash_miss_tracker #(
      .NUM_LINES(NUM_LINES), .WORDS(WORDS), .TAG_W(TAG_W), .MAP_W(MAP_W)
   ) i_miss (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue        (issue),
      .issue_reg    (acc_write),
      .issue_line   (acc_line),
      .issue_word   (acc_word),
      .issue_tag    (acc_tag),
      .issue_map    (acc_map_idx),
      .req_ready    (req_ready),
      .rsp_valid    (rsp_valid),
      .rsp_line     (rsp_line),
      .req_valid    (req_valid),
      .req_register (req_register),
      .req_line     (req_line),
      .req_word     (req_word),
      .req_tag      (req_tag),
      .req_map_idx  (req_map_idx),
      .busy         (busy),
      .reg_busy_any (reg_busy_any)
   );

   stash_kend_seq i_kend (
      .clk          (clk),
      .rst_n        (rst_n),
      .kend_pulse   (kernel_end),
      .reg_busy_any (reg_busy_any),
      .fire         (kend_fire),
      .hold_q       (kend_hold)
   );
endmodule

// File: rtl/stash_coh_ctrl_chk.sv
module stash_coh_ctrl_chk #(
   parameter int WORDS   = 16,
   parameter int MAP_W   = 6,
   localparam int WORD_W = $clog2(WORDS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_ready,
   input logic              acc_write,
   input logic              acc_hit,
   input logic [MAP_W-1:0]  acc_map_idx,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_register,
   input logic [WORD_W-1:0] req_word,
   input logic [MAP_W-1:0]  req_map_idx
);
   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_word) && $stable(req_register));
   // R2
   store_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_ready && acc_write && acc_hit |=> !req_valid);
   // R4
   miss_issues_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_ready && !acc_hit |=> req_valid && (req_register == $past(acc_write)));
   // R3
   map_idx_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_ready && acc_write && !acc_hit |=> req_map_idx == $past(acc_map_idx));
   // R7
   no_accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !acc_ready);
endmodule

bind stash_coh_ctrl stash_coh_ctrl_chk #(.WORDS(WORDS), .MAP_W(MAP_W)) i_chk (.*);

// File: tb/test_stash_coh_ctrl.sv
`timescale 1ns/1ps
module test_stash_coh_ctrl;
   localparam int LINE_W = 2, WORD_W = 4, TAG_W = 20, MAP_W = 6, CORE_W = 4, WORDS = 16;
   localparam int CORE_ID = 3;

   logic clk = 0, rst_n = 0;
   logic acc_valid = 0, acc_write = 0, acc_ready, acc_hit;
   logic [LINE_W-1:0] acc_line = '0;
   logic [WORD_W-1:0] acc_word = '0;
   logic [TAG_W-1:0]  acc_tag = '0;
   logic [MAP_W-1:0]  acc_map_idx = '0;
   logic req_valid, req_ready = 1, req_register;
   logic [CORE_W-1:0] req_core;
   logic [MAP_W-1:0]  req_map_idx;
   logic [LINE_W-1:0] req_line;
   logic [WORD_W-1:0] req_word;
   logic [TAG_W-1:0]  req_tag;
   logic rsp_valid = 0, rsp_register = 0, kernel_end = 0;
   logic [LINE_W-1:0] rsp_line = '0;
   logic [WORDS-1:0]  rsp_mask = '0;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   stash_coh_ctrl #(.CORE_ID(CORE_ID)) i_stash_coh_ctrl (.*);

   task automatic check(input string rq, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic access(input bit wr, input int line, input int word, input int tag,
                         output bit hit, output bit rdy);
      @(negedge clk);
      acc_valid = 1; acc_write = wr; acc_line = LINE_W'(line); acc_word = WORD_W'(word);
      acc_tag = TAG_W'(tag); acc_map_idx = MAP_W'(line * 16 + word);
      #1; hit = acc_hit; rdy = acc_ready;
      @(posedge clk); #1;
      acc_valid = 0;
   endtask

   task automatic respond(input bit rg, input int line, input logic [WORDS-1:0] mask);
      @(negedge clk);
      rsp_valid = 1; rsp_register = rg; rsp_line = LINE_W'(line); rsp_mask = mask;
      @(posedge clk); #1;
      rsp_valid = 0;
   endtask

   task automatic pulse_kend();
      @(negedge clk); kernel_end = 1;
      @(posedge clk); #1; kernel_end = 0;
   endtask

   // run one access, check hit, and serve a miss with a single-word response
   task automatic step(input string rq, input bit wr, input int line, input int word,
                       input int tag, input bit exp_hit);
      bit h, r;
      access(wr, line, word, tag, h, r);
      check({rq, " ready"}, r, 1);
      check({rq, " hit"}, h, exp_hit);
      if (!exp_hit && !h) begin
         check({rq, " req_valid"}, req_valid, 1);
         check({rq, " req_register"}, req_register, wr);
         check({rq, " req_word"}, req_word, word);
         check({rq, " req_line"}, req_line, line);
         if (wr) begin
            check("R3 req_core", req_core, CORE_ID);
            check("R3 req_map_idx", req_map_idx, line * 16 + word);
            check("R3 req_tag", req_tag, tag);
         end
         respond(wr, line, WORDS'(1) << word);
      end
   endtask

   localparam int VN = 8;
   localparam bit V_WR  [VN] = '{0, 0, 1, 1, 0, 1, 1, 0};
   localparam int V_LN  [VN] = '{0, 0, 0, 0, 0, 1, 1, 1};
   localparam int V_WD  [VN] = '{0, 0, 0, 0, 0, 3, 3, 2};
   localparam bit V_HIT [VN] = '{0, 1, 0, 1, 1, 0, 1, 0};

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit h, r;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #1;
      check("R1 reset acc_ready", acc_ready, 1);
      check("R1 reset req_valid", req_valid, 0);

      // R1 R2 R4 R6: table walk (first row misses from reset)
      for (int i = 0; i < VN; i++)
         step(V_WR[i] ? "R2" : "R4", V_WR[i], V_LN[i], V_WD[i], 5, V_HIT[i]);

      // R7 R8: request held under back-pressure
      req_ready = 0;
      access(0, 3, 0, 5, h, r);
      check("R4 L3 miss", h, 0);
      repeat (2) @(posedge clk);
      #1;
      check("R8 req held", req_valid, 1);
      check("R8 req_word stable", req_word, 0);
      acc_line = 2'd2; #0.5;
      check("R7 ready low while req pending", acc_ready, 0);
      @(negedge clk); req_ready = 1;
      @(posedge clk); #1;
      check("R8 req taken", req_valid, 0);
      acc_line = 2'd3; #0.5;
      check("R7 busy line blocks", acc_ready, 0);
      acc_line = 2'd2; #0.5;
      check("R7 other line open", acc_ready, 1);

      // R5: partial response words 0 and 4 only
      respond(0, 3, 16'h0011);
      step("R5 carried word", 0, 3, 4, 5, 1);
      step("R5 uncarried word", 0, 3, 5, 5, 0);
      respond(0, 1, 16'h0048);   // read covering registered word 3 and word 6
      step("R5 no downgrade", 1, 1, 3, 5, 1);
      step("R5 read sets valid", 0, 1, 6, 5, 1);

      // R9: kernel end with nothing outstanding
      pulse_kend();
      step("R9 registered kept", 1, 0, 0, 5, 1);
      step("R9 valid dropped", 0, 1, 6, 5, 0);

      // R10: kernel end held behind a registration
      step("R10 setup", 0, 2, 4, 5, 0);
      access(1, 2, 7, 5, h, r);
      check("R2 store miss on invalid", h, 0);
      pulse_kend();
      acc_line = 2'd0; #0.5;
      check("R10 ready low while held", acc_ready, 0);
      respond(1, 2, 16'h0080);
      @(posedge clk); #1;
      step("R10 registered kept", 1, 2, 7, 5, 1);
      step("R10 valid dropped", 0, 2, 4, 5, 0);

      // R11: tag change reallocates the line
      step("R11 new tag misses", 0, 0, 0, 9, 0);
      step("R11 new tag now valid", 0, 0, 0, 9, 1);
      step("R11 old registration cleared", 1, 0, 0, 9, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule